// File: doc/BRIEF.md
# Banked Working-Register File with Indirect Access

The block sits in front of a small internal data RAM. It gives software eight working registers, and those registers are ordinary RAM bytes. A bank bit chooses which of two address windows the registers use. The same RAM is also reached indirectly: the byte held in working register 0 or 1 of the active bank becomes the address. The internal RAM depth is a parameter, 64 or 128 bytes.

An external-data path uses the same pointer registers. It places all eight pointer bits on an address bus that reaches 256 external locations. It raises a read or write strobe for one cycle and captures the returned read byte at the clock edge that closes that cycle.

A request is presented for a single cycle on `acc_en`, `acc_wr`, `acc_ind`, `acc_ext`, `reg_idx` and `wr_data`. A bank change is a separate single-cycle command on `bank_cmd` and `bank_val`.

Top module: `regbank_ram`

## Requirements
- R1: With the bank bit at 0, working register n (given on `reg_idx`) is internal RAM address n, for n from 0 to 7.
- R2: With the bank bit at 1, working register n is internal RAM address 24+n.
- R3: The bank bit is 0 after reset. It takes `bank_val` at the edge that ends a cycle with `bank_cmd` high, and it holds in every other cycle, whatever accesses occur.
- R4: An indirect access (`acc_ind`=1) takes its address from working register 0 of the active bank when `reg_idx[0]`=0, and from working register 1 when `reg_idx[0]`=1.
- R5: For an internal indirect access only the low log2(RAM_DEPTH) bits of the pointer are used. With a 64-byte RAM, pointer 0x45 selects address 5.
- R6: An external access (`acc_en` and `acc_ext` high) always uses the pointer, whatever `acc_ind` is. In the request cycle it drives all 8 pointer bits on `x_addr` and drives `wr_data` on `x_wdata`. It raises `x_wr_stb` for a write or `x_rd_stb` for a read, never both at once.
- R7: `xrd_data` is 0 after reset. It loads `x_rdata` at the edge that ends a cycle with `x_rd_stb` high, and it holds otherwise.
- R8: Indirect accesses read and write any internal location. This includes bank-0 registers while bank 1 is active, and locations outside both register windows, which act as plain scratch bytes.
- R9: `rd_data` is a combinational read of the addressed internal byte. A write lands at the rising edge, so a read of the address being written in the same cycle returns the old value.
- R10: An external access writes no internal byte. Both strobes stay low in every cycle without an external request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_cmd | input | 1 | Bank-select command |
| bank_val | input | 1 | Bank to select (0 or 1) |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_ind | input | 1 | 1 = indirect through R0/R1 |
| acc_ext | input | 1 | 1 = external data access |
| reg_idx | input | 3 | Working register index; bit 0 picks the pointer |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Internal read data, combinational |
| x_addr | output | 8 | External address (full pointer) |
| x_wdata | output | 8 | External write data |
| x_rd_stb | output | 1 | External read strobe |
| x_wr_stb | output | 1 | External write strobe |
| x_rdata | input | 8 | External read data |
| xrd_data | output | 8 | Captured external read data |

## Verification
Internal read data, the external address, the strobes and the external write data are all due in the request cycle itself. The bench samples them 1 ns before the rising edge that closes that cycle. Captured external read data and the effects of writes and bank changes become visible in the next cycle. Each expected item in the queue carries the cycle number at which it falls due, and the monitor compares it only in that cycle's sampling slot.

// File: rtl/regbank_ram.sv
module regbank_ram #(
  parameter int RAM_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bank_cmd,
  input  logic       bank_val,
  input  logic       acc_en,
  input  logic       acc_wr,
  input  logic       acc_ind,
  input  logic       acc_ext,
  input  logic [2:0] reg_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [7:0] x_addr,
  output logic [7:0] x_wdata,
  output logic       x_rd_stb,
  output logic       x_wr_stb,
  input  logic [7:0] x_rdata,
  output logic [7:0] xrd_data
);
  localparam int AW      = $clog2(RAM_DEPTH);
  localparam int B1_BASE = 24;

  logic [7:0]    mem [RAM_DEPTH];
  logic          bank_q;
  logic [AW-1:0] win_base, reg_addr, ptr_loc, int_addr;
  logic [7:0]    ptr;
  logic          is_ext;

  assign win_base = bank_q ? AW'(B1_BASE) : AW'(0);
  assign reg_addr = win_base + AW'(reg_idx);
  assign ptr_loc  = win_base + AW'(reg_idx[0]);
  assign ptr      = mem[ptr_loc];
  assign int_addr = acc_ind ? ptr[AW-1:0] : reg_addr;
  assign rd_data  = mem[int_addr];

  assign is_ext   = acc_en & acc_ext;
  assign x_addr   = ptr;
  assign x_wdata  = wr_data;
  assign x_rd_stb = is_ext & ~acc_wr;
  assign x_wr_stb = is_ext & acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      xrd_data <= 8'h00;
    end else begin
      if (bank_cmd) bank_q <= bank_val;
      if (x_rd_stb) xrd_data <= x_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en && acc_wr && !acc_ext) mem[int_addr] <= wr_data;
  end
endmodule

// File: rtl/regbank_ram_chk.sv
module regbank_ram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bank_cmd,
  input logic       bank_val,
  input logic       bank_q,
  input logic       acc_en,
  input logic       acc_ext,
  input logic [7:0] wr_data,
  input logic [7:0] x_wdata,
  input logic       x_rd_stb,
  input logic       x_wr_stb,
  input logic [7:0] x_rdata,
  input logic [7:0] xrd_data
);
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !bank_cmd |=> $stable(bank_q)); // R3
  AST_BANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n) bank_cmd |=> bank_q == $past(bank_val)); // R3
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(x_rd_stb && x_wr_stb)); // R6
  AST_WDATA_OUT: assert property (@(posedge clk) disable iff (!rst_n) x_wr_stb |-> x_wdata == wr_data); // R6
  AST_STB_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (x_rd_stb || x_wr_stb) |-> (acc_en && acc_ext)); // R10
  AST_XRD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) x_rd_stb |=> xrd_data == $past(x_rdata)); // R7
  AST_XRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !x_rd_stb |=> $stable(xrd_data)); // R7
endmodule

bind regbank_ram regbank_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bank_cmd(bank_cmd), .bank_val(bank_val),
  .bank_q(bank_q), .acc_en(acc_en), .acc_ext(acc_ext), .wr_data(wr_data),
  .x_wdata(x_wdata), .x_rd_stb(x_rd_stb), .x_wr_stb(x_wr_stb),
  .x_rdata(x_rdata), .xrd_data(xrd_data)
);

// File: tb/sim_regbank_ram.sv
`timescale 1ns/1ps
module sim_regbank_ram;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bank_cmd = 0, bank_val = 0, acc_en = 0, acc_wr = 0, acc_ind = 0, acc_ext = 0;
  logic [2:0] reg_idx = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, x_addr, x_wdata, x_rdata, xrd_data;
  logic x_rd_stb, x_wr_stb;

  always #2.5 clk = ~clk;

  regbank_ram #(.RAM_DEPTH(64)) u0 (
    .clk(clk), .rst_n(rst_n), .bank_cmd(bank_cmd), .bank_val(bank_val),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_ind(acc_ind), .acc_ext(acc_ext),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data), .x_addr(x_addr),
    .x_wdata(x_wdata), .x_rd_stb(x_rd_stb), .x_wr_stb(x_wr_stb),
    .x_rdata(x_rdata), .xrd_data(xrd_data)
  );

  logic [7:0] ext_mem [256];
  initial for (int i = 0; i < 256; i++) ext_mem[i] = 8'h00;
  assign x_rdata = ext_mem[x_addr];
  always @(posedge clk) if (x_wr_stb) ext_mem[x_addr] <= x_wdata;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { string tag; int sel; logic [7:0] exp; int due; } item_t;
  item_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic void push(string tag, int sel, logic [7:0] exp, int due);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp; it.due = due;
    q.push_back(it);
  endfunction

  initial forever begin
    @(negedge clk); #1.5;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rd_data;
        1: act = x_addr;
        2: act = xrd_data;
        3: act = {6'd0, x_rd_stb, x_wr_stb};
        default: act = x_wdata;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s (item %0d) actual %02h expected %02h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic idle(input bit chk_x, input logic [7:0] xexp, input string tag);
    @(negedge clk);
    bank_cmd = 0; acc_en = 0; acc_wr = 0; acc_ind = 0; acc_ext = 0;
    push({tag, " strobes quiet"}, 3, 8'h00, cyc);
    if (chk_x) push({tag, " xrd_data"}, 2, xexp, cyc);
  endtask

  task automatic bank(input bit b);
    @(negedge clk);
    bank_cmd = 1; bank_val = b; acc_en = 0; acc_wr = 0; acc_ind = 0; acc_ext = 0;
  endtask

  task automatic op(input bit wr, input bit ind, input bit ext, input logic [2:0] idx,
                    input logic [7:0] wd, input bit chk, input logic [7:0] exp_rd,
                    input logic [7:0] exp_xa, input string tag);
    @(negedge clk);
    bank_cmd = 0; acc_en = 1; acc_wr = wr; acc_ind = ind; acc_ext = ext;
    reg_idx = idx; wr_data = wd;
    if (ext) begin
      push({tag, " x_addr"}, 1, exp_xa, cyc);
      push({tag, " strobes"}, 3, {6'd0, !wr, wr}, cyc);
      if (wr) push({tag, " x_wdata"}, 4, wd, cyc);
      else    push({tag, " xrd_data"}, 2, exp_rd, cyc + 1);
    end else begin
      push({tag, " strobes quiet R10"}, 3, 8'h00, cyc);
      if (chk) push({tag, " rd_data"}, 0, exp_rd, cyc);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1, 8'h00, "R7 reset capture reg");
    op(1, 0, 0, 3'd3, 8'hA3, 0, 0, 0, "R1 setup");
    op(1, 0, 0, 3'd0, 8'h03, 0, 0, 0, "R1 setup");
    op(0, 1, 0, 3'd0, 0, 1, 8'hA3, 0, "R1 R3 R4 bank0 reg3 via R0");
    bank(1);
    op(1, 0, 0, 3'd5, 8'h5B, 0, 0, 0, "R2 setup");
    op(1, 0, 0, 3'd1, 8'h03, 0, 0, 0, "R4 setup");
    op(0, 1, 0, 3'd1, 0, 1, 8'hA3, 0, "R8 R4 bank0 reg via bank1 R1");
    op(0, 0, 0, 3'd5, 0, 1, 8'h5B, 0, "R3 bank still 1");
    op(1, 0, 0, 3'd0, 8'h45, 0, 0, 0, "R5 setup");
    op(1, 1, 0, 3'd0, 8'h77, 0, 0, 0, "R5 truncated write");
    bank(0);
    op(0, 0, 0, 3'd5, 0, 1, 8'h77, 0, "R5 pointer 0x45 hit addr 5");
    op(1, 0, 0, 3'd0, 8'h1D, 0, 0, 0, "R2 setup");
    op(0, 1, 0, 3'd0, 0, 1, 8'h5B, 0, "R2 bank1 reg5 is addr 29");
    op(1, 0, 0, 3'd1, 8'h28, 0, 0, 0, "R8 setup");
    op(1, 1, 0, 3'd1, 8'h99, 0, 0, 0, "R8 scratch write");
    op(0, 1, 0, 3'd1, 0, 1, 8'h99, 0, "R8 scratch addr 40");
    op(1, 0, 0, 3'd0, 8'hC5, 0, 0, 0, "R6 setup");
    op(1, 1, 1, 3'd0, 8'h3C, 0, 0, 8'hC5, "R6 ext write");
    op(0, 0, 1, 3'd0, 0, 0, 8'h3C, 8'hC5, "R6 R7 ext read");
    idle(1, 8'h3C, "R7 hold");
    idle(1, 8'h3C, "R7 hold");
    op(0, 0, 0, 3'd5, 0, 1, 8'h77, 0, "R10 addr5 untouched by ext");
    op(1, 0, 0, 3'd2, 8'h11, 0, 0, 0, "R9 setup");
    op(1, 0, 0, 3'd2, 8'h22, 1, 8'h11, 0, "R9 old value in write cycle");
    op(0, 0, 0, 3'd2, 0, 1, 8'h22, 0, "R9 new value");
    idle(0, 0, "R10 idle");
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule